// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table, one byte each of red, green and blue per entry, and lets a processor fill it through a small write-only register window. A write to the pointer register picks the entry to load. Writes to the colour register then deliver the entry's components in a fixed red, green, blue order, one component per bus write. The component value always sits in the most significant byte of the 32-bit write word.

The entry pointer never advances by itself. After the blue component is stored, the next colour write starts again at red on the same entry. To load a different entry, software writes the pointer register again, and that write also restarts the component order at red. The display pipeline reads the tables through its own port: it presents an 8-bit pixel code and gets that entry's three components back combinationally. Bus reads of the window always return zero.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads red = green = blue = 0x00, except entry 255, which reads 0xFF in all three components. The pointer and the component step both start at 0, so the first colour write lands in red of entry 0.
- R2: The register slot is `bus_addr[3:2]`. Slot 0 is the pointer and slot 1 is colour data. Writes to slots 2 and 3 change no table entry, pointer or component step. `bus_addr[1:0]` has no effect on decoding.
- R3: A slot 0 write loads the pointer from `bus_wdata[31:24]` and returns the component step to red.
- R4: A slot 1 write while the step is at red stores `bus_wdata[31:24]` into the red table at the pointer and moves the step to green.
- R5: A slot 1 write while the step is at green stores the byte into the green table at the pointer and moves the step to blue.
- R6: A slot 1 write while the step is at blue stores the byte into the blue table at the pointer and moves the step back to red. The step never takes any value other than red, green or blue.
- R7: The pointer keeps its value across colour writes, so a fourth colour write after a blue store rewrites red of the same entry.
- R8: A slot 0 write in the middle of a sequence abandons it. The next colour write goes to red, and components already stored stay in place.
- R9: `bus_rdata` is zero in every cycle.
- R10: `pix_red`, `pix_grn` and `pix_blu` show the three table components of the entry selected by `pix_code`, with no clock delay. A write that lands on that same entry shows up after the clock edge that performs it.
- R11: `bus_wdata[23:0]` never affects any table entry or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Byte address within the register window |
| bus_wdata | input | 32 | Write data; the component or pointer value is bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| pix_code | input | 8 | Pixel code that selects the table entry for the display side |
| pix_red | output | 8 | Red component of the selected entry |
| pix_grn | output | 8 | Green component of the selected entry |
| pix_blu | output | 8 | Blue component of the selected entry |

## Verification
The hidden component step is the hardest state to reach from the ports. It can only be seen through where the next colour byte lands. Reaching it with the pointer reloaded at green or at blue, or with spare-slot writes placed between colour writes, takes exact write sequences. The stimulus therefore runs directed sequences that stop at each step and then reload or write a spare slot. It ends with a long stream of pseudo-random writes that mixes all four slots, non-zero low address and data bits, and pixel codes that often hit the entry being loaded. A behavioural model tracks the pointer, the step and all three tables, and the outputs are compared after every write and in full sweeps of all 256 entries.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // colour component step of the data register sequence
  typedef enum logic [1:0] {
    CMP_RED = 2'd0,
    CMP_GRN = 2'd1,
    CMP_BLU = 2'd2,
    CMP_BAD = 2'd3
  } comp_e;

  // word slots of the register window (address bits 3:2)
  typedef enum logic [1:0] {
    SLOT_PTR   = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_SPR_A = 2'd2,
    SLOT_SPR_B = 2'd3
  } slot_e;

  localparam int NUM_COMP = 3;
  localparam int WIN_AW   = 4;

endpackage

// File: rtl/clut_rst_sync.sv
module clut_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_slot,
  input  logic [COMP_W-1:0]   wr_byte,
  output logic [NUM_COMP-1:0] tab_we,
  output logic [IDX_W-1:0]    tab_idx,
  output logic [COMP_W-1:0]   tab_val
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  comp_e            step_q, step_d;
  logic             step_en;

  // next-state logic
  always_comb begin
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    step_d  = step_q;
    step_en = 1'b0;
    tab_we  = '0;
    if (wr_en) begin
      case (slot_e'(wr_slot))
        SLOT_PTR: begin
          ptr_d   = wr_byte[IDX_W-1:0];
          ptr_en  = 1'b1;
          step_d  = CMP_RED;
          step_en = 1'b1;
        end
        SLOT_DATA: begin
          step_en = 1'b1;
          case (step_q)
            CMP_RED: begin
              tab_we[0] = 1'b1;
              step_d    = CMP_GRN;
            end
            CMP_GRN: begin
              tab_we[1] = 1'b1;
              step_d    = CMP_BLU;
            end
            CMP_BLU: begin
              tab_we[2] = 1'b1;
              step_d    = CMP_RED;
            end
            default: begin
              step_d = CMP_RED;
            end
          endcase
        end
        default: begin
          ptr_en  = 1'b0;
          step_en = 1'b0;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= CMP_RED;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign tab_idx = ptr_q;
  assign tab_val = wr_byte;

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != CMP_BAD);

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 2'd0) |=>
      (ptr_q == $past(wr_byte[IDX_W-1:0]) && step_q == CMP_RED));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_slot == 2'd0) |=> $stable(ptr_q));

  // R4
  red_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 2'd1 && step_q == CMP_RED) |=> step_q == CMP_GRN);

  // R5
  grn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == 2'd1 && step_q == CMP_GRN) |=> step_q == CMP_BLU);

  // R2
  spare_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot[1]) |=> $stable(step_q));

  // R6
  one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tab_we));

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int DEPTH  = 256,
  parameter int COMP_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [COMP_W-1:0] rdata
);

  logic [COMP_W-1:0] mem_q [DEPTH];

  // the last entry resets to full scale, all others to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= (i == DEPTH - 1) ? {COMP_W{1'b1}} : '0;
      end
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R4
  store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int COMP_W = 8,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [IDX_W-1:0]  pix_code,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_grn,
  output logic [COMP_W-1:0] pix_blu
);

  logic                rst_core_n;
  logic [1:0]          slot;
  logic [COMP_W-1:0]   wr_byte;
  logic [NUM_COMP-1:0] tab_we;
  logic [IDX_W-1:0]    tab_idx;
  logic [COMP_W-1:0]   tab_val;
  logic [COMP_W-1:0]   comp_rd [NUM_COMP];
  logic                unused_bits;

  clut_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign slot        = bus_addr[3:2];
  assign wr_byte     = bus_wdata[BUS_W-1 -: COMP_W];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-COMP_W-1:0]};

  clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (bus_wr),
    .wr_slot (slot),
    .wr_byte (wr_byte),
    .tab_we  (tab_we),
    .tab_idx (tab_idx),
    .tab_val (tab_val)
  );

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_tab
    clut_bank #(.DEPTH(DEPTH), .COMP_W(COMP_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_core_n),
      .we    (tab_we[g]),
      .waddr (tab_idx),
      .wdata (tab_val),
      .raddr (pix_code),
      .rdata (comp_rd[g])
    );
  end

  assign pix_red   = comp_rd[0];
  assign pix_grn   = comp_rd[1];
  assign pix_blu   = comp_rd[2];
  assign bus_rdata = '0;

endmodule

// File: tb/clut_loader_tb.sv
module clut_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_code = '0;
  logic [7:0]  pix_red, pix_grn, pix_blu;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int ref_tab [3][256];
  int ref_ptr;
  int ref_step;

  always #4 clk = ~clk;

  clut_loader u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_code  (pix_code),
    .pix_red   (pix_red),
    .pix_grn   (pix_grn),
    .pix_blu   (pix_blu)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      for (int c = 0; c < 3; c++) ref_tab[c][i] = (i == 255) ? 255 : 0;
    end
    ref_ptr  = 0;
    ref_step = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    int b;
    b = int'(d[31:24]);
    if (a[3:2] == 2'd0) begin
      ref_ptr  = b;
      ref_step = 0;
    end else if (a[3:2] == 2'd1) begin
      ref_tab[ref_step][ref_ptr] = b;
      ref_step = (ref_step + 1) % 3;
    end
  endtask

  task automatic check_entry(input string tag, input int p);
    chk({tag, " red"}, int'(pix_red), ref_tab[0][p]);
    chk({tag, " grn"}, int'(pix_grn), ref_tab[1][p]);
    chk({tag, " blu"}, int'(pix_blu), ref_tab[2][p]);
  endtask

  // one write per call; called at a falling edge, returns at the next one
  task automatic do_wr(input logic [3:0] a, input logic [31:0] d,
                       input int p, input string tag);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    pix_code  = p[7:0];
    @(posedge clk);
    #1;
    model_write(a, d);
    bus_wr = 1'b0;
    @(negedge clk);
    check_entry(tag, p);
    chk("R9 rdata", int'(bus_rdata), 0);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 256; i++) begin
      pix_code = i[7:0];
      #0.5;
      check_entry(tag, i);
    end
    chk("R9 rdata", int'(bus_rdata), 0);
  endtask

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset contents
    sweep("R1 reset");
    // R1 first colour write goes to red of entry 0
    do_wr(4'h4, 32'h3C00_0000, 0, "R1 first write");

    // R3 R4 R5 R6 full sequence on entry 5
    do_wr(4'h0, 32'h0500_0000, 5, "R3 ptr");
    do_wr(4'h4, 32'hA100_0000, 5, "R4 red");
    do_wr(4'h4, 32'hB200_0000, 5, "R5 grn");
    do_wr(4'h4, 32'hC300_0000, 5, "R6 blu");
    // R7 pointer held, wraps to red on same entry
    do_wr(4'h4, 32'hD400_0000, 5, "R7 rewrite red");
    do_wr(4'h4, 32'hE500_0000, 5, "R7 rewrite grn");

    // R8 restart at green and at blue
    do_wr(4'h0, 32'h0900_0000, 9, "R8 ptr");
    do_wr(4'h4, 32'h1100_0000, 9, "R8 red");
    do_wr(4'h0, 32'h0900_0000, 9, "R8 reload");
    do_wr(4'h4, 32'h2200_0000, 9, "R8 red again");
    do_wr(4'h4, 32'h3300_0000, 9, "R8 grn");
    do_wr(4'h0, 32'h0A00_0000, 9, "R8 reload other");
    do_wr(4'h4, 32'h4400_0000, 10, "R8 red of 10");

    // R2 spare slots and low address bits
    do_wr(4'h8, 32'h7700_0000, 10, "R2 slot2");
    do_wr(4'hC, 32'h0300_0000, 10, "R2 slot3");
    do_wr(4'hB, 32'h0400_0000, 10, "R2 slot2 odd");
    do_wr(4'h5, 32'h5500_0000, 10, "R2 data odd addr");
    do_wr(4'h3, 32'hFE00_0000, 254, "R2 ptr odd addr");
    do_wr(4'h6, 32'h6600_0000, 254, "R2 data");

    // R11 low data bits ignored
    do_wr(4'h0, 32'h00FF_FFFF, 0, "R11 ptr");
    do_wr(4'h4, 32'h8812_3456, 0, "R11 red");
    do_wr(4'h4, 32'h00FF_FFFF, 0, "R11 grn");
    do_wr(4'h4, 32'h99AB_CDEF, 0, "R11 blu");

    // R10 entry 255 overwrite
    do_wr(4'h0, 32'hFF00_0000, 255, "R10 ptr 255");
    do_wr(4'h4, 32'h1000_0000, 255, "R10 red 255");
    sweep("R10 sweep");

    // R10 mixed stream
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      int          p;
      a = $urandom_range(0, 15);
      if ($urandom_range(0, 3) != 0) a[3:2] = 2'd1;
      d = $urandom;
      p = ($urandom_range(0, 1) != 0) ? ref_ptr : $urandom_range(0, 255);
      do_wr(a, d, p, "R10 stream");
    end
    sweep("R10 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule